// File: doc/BRIEF.md
# Serial Clock-Synthesizer Programming Sequencer

This block sits on the host side of a board and loads one frequency setting into an external programmable clock synthesizer over two bit-banged lines, a serial clock line and a serial data line. A request carries a feedback value n, a reference divider value m, a two-bit post-divider code, a four-bit clock index and a two-bit register number. The synthesizer output is reference × n / m / divider. The divider code selects ÷1, ÷2, ÷4 or ÷8 for codes 0 to 3.

When a valid request is accepted, the block packs the fields into a 24-bit command word. It then walks a fixed choreography of line states. First come two opening states, then an unlock preamble of repeated pairs, then a start pattern, then the word least-significant bit first with four states per bit, and finally a stop pattern. The sequence advances one state per pulse of an enable tick, so the caller sets the line rate.

A request whose n or m falls outside its legal range is refused with a one-cycle error pulse. Nothing is transmitted for a refused request.

Top module: `clksyn_prog_seq`

## Requirements
- R1: The command word places m−2 in bits 7:1, the divider code in bits 9:8, n−3 in bits 17:11, the clock index in bits 21:18 and the register number in bits 23:22.
- R2: Command word bits 0 and 10 are always sent as 0.
- R3: A start in idle with n outside 3..130 or m outside 2..129 raises err_o for exactly the next cycle; busy_o stays low and the lines stay 0/0.
- R4: An accepted transfer shows (clock/data) 0/0 and then 0/1, followed by UNLOCK_PAIRS (default 6) repetitions of the pair 1/1, 0/1.
- R5: After the preamble the lines show 0/0, 1/0, 0/0, 1/0.
- R6: Each word bit b, taken LSB first, is sent as four states: 1/~b, 0/~b, 0/b, 1/b.
- R7: After the last word bit the lines show 1/1, 0/1, 1/1.
- R8: busy_o rises the cycle after an accepted start, with the lines at the first state. Each tick while busy moves the lines to the next state in the following cycle, and the lines hold while tick_i is low. A tick on the final state drops busy_o and pulses done_o for one cycle.
- R9: While busy_o is low the lines rest at 0/0. A start while busy_o is high is ignored and leaves the stream unchanged.
- R10: After synchronous reset, busy_o, done_o, err_o, sclk_o and sdata_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Line-step enable pulse |
| start_i | input | 1 | Request strobe, sampled while idle |
| n_i | input | VAL_W | Feedback value n (3..130) |
| m_i | input | VAL_W | Reference divider m (2..129) |
| div_i | input | 2 | Post-divider code |
| sel_i | input | 4 | Clock index |
| reg_i | input | 2 | Register number |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle out-of-range refusal pulse |
| sclk_o | output | 1 | Serial clock line |
| sdata_o | output | 1 | Serial data line |

## Verification
The assertions assume that tick_i and start_i are synchronous to clk and never unknown. They also assume that request fields matter only in the cycle start_i is sampled while idle. The stimulus changes every input on the falling edge. It lowers start_i after one cycle, except when it deliberately strobes start_i during a transfer with different fields to show that the strobe is ignored. The tick runs in three modes: off, sparse random, and every cycle. This covers held states, a tick that coincides with the accepting start, and a new start in the same cycle as done_o.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int CMD_W   = 24;
  localparam int FLD_W   = 7;
  localparam int M_LSB   = 1;
  localparam int DIV_LSB = 8;
  localparam int GAP_BIT = 10;
  localparam int N_LSB   = 11;
  localparam int SEL_LSB = 18;
  localparam int SEL_W   = 4;
  localparam int REG_LSB = 22;
  localparam int REG_W   = 2;
  localparam int DIV_W   = 2;
  localparam int M_MIN   = 2;
  localparam int M_MAX   = 129;
  localparam int N_MIN   = 3;
  localparam int N_MAX   = 130;

  typedef struct packed {
    logic ck;
    logic dt;
  } line_t;
endpackage

// File: rtl/clksyn_word_pack.sv
module clksyn_word_pack
  import clksyn_pkg::*;
#(
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0] n_i,
  input  logic [VAL_W-1:0] m_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [REG_W-1:0] reg_i,
  output logic [CMD_W-1:0] word_o,
  output logic             ok_o
);
  logic [FLD_W-1:0] n_fld, m_fld;
  logic             n_ok, m_ok;

  always_comb begin
    n_ok  = (n_i >= VAL_W'(N_MIN)) && (n_i <= VAL_W'(N_MAX));
    m_ok  = (m_i >= VAL_W'(M_MIN)) && (m_i <= VAL_W'(M_MAX));
    ok_o  = n_ok && m_ok;
    n_fld = FLD_W'(n_i - VAL_W'(N_MIN));
    m_fld = FLD_W'(m_i - VAL_W'(M_MIN));
    word_o = '0;
    word_o[M_LSB   +: FLD_W] = m_fld;
    word_o[DIV_LSB +: DIV_W] = div_i;
    word_o[N_LSB   +: FLD_W] = n_fld;
    word_o[SEL_LSB +: SEL_W] = sel_i;
    word_o[REG_LSB +: REG_W] = reg_i;
  end
endmodule

// File: rtl/clksyn_line_decode.sv
module clksyn_line_decode
  import clksyn_pkg::*;
#(
  parameter int UNLOCK_PAIRS = 6,
  parameter int IDX_W        = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CMD_W-1:0] word_i,
  output line_t            line_o
);
  localparam logic [IDX_W-1:0] OPEN_END  = IDX_W'(2);
  localparam logic [IDX_W-1:0] PRE_END   = IDX_W'(2 + 2*UNLOCK_PAIRS);
  localparam logic [IDX_W-1:0] START_END = IDX_W'(2 + 2*UNLOCK_PAIRS + 4);
  localparam logic [IDX_W-1:0] DATA_END  = IDX_W'(2 + 2*UNLOCK_PAIRS + 4 + 4*CMD_W);

  logic [IDX_W-1:0] k;
  logic             bitv;

  always_comb begin
    k    = '0;
    bitv = 1'b0;
    if (idx_i < OPEN_END) begin
      line_o.ck = 1'b0;
      line_o.dt = idx_i[0];
    end else if (idx_i < PRE_END) begin
      k = idx_i - OPEN_END;
      line_o.ck = ~k[0];
      line_o.dt = 1'b1;
    end else if (idx_i < START_END) begin
      k = idx_i - PRE_END;
      line_o.ck = k[0];
      line_o.dt = 1'b0;
    end else if (idx_i < DATA_END) begin
      k    = idx_i - START_END;
      bitv = word_i[k[IDX_W-1:2]];
      line_o.ck = (k[1:0] == 2'd0) || (k[1:0] == 2'd3);
      line_o.dt = k[1] ? bitv : ~bitv;
    end else begin
      k = idx_i - DATA_END;
      line_o.ck = ~k[0];
      line_o.dt = 1'b1;
    end
  end
endmodule

// File: rtl/clksyn_prog_seq.sv
module clksyn_prog_seq
  import clksyn_pkg::*;
#(
  parameter int VAL_W        = 8,
  parameter int UNLOCK_PAIRS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [VAL_W-1:0] n_i,
  input  logic [VAL_W-1:0] m_i,
  input  logic [1:0]       div_i,
  input  logic [3:0]       sel_i,
  input  logic [1:0]       reg_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             sclk_o,
  output logic             sdata_o
);
  localparam int TOTAL = 2 + 2*UNLOCK_PAIRS + 4 + 4*CMD_W + 3;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

  logic             busy_q, done_q, err_q;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [CMD_W-1:0] word_q, word_n, pack_word;
  line_t            line_q, dec_line;
  logic             busy_n, done_n, err_n, pack_ok;

  clksyn_word_pack #(.VAL_W(VAL_W)) pack_i (
    .n_i(n_i), .m_i(m_i), .div_i(div_i), .sel_i(sel_i), .reg_i(reg_i),
    .word_o(pack_word), .ok_o(pack_ok)
  );

  // Next-state logic: accept in idle, step on tick while busy.
  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    word_n = word_q;
    done_n = 1'b0;
    err_n  = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        if (pack_ok) begin
          busy_n = 1'b1;
          idx_n  = '0;
          word_n = pack_word;
        end else begin
          err_n = 1'b1;
        end
      end
    end else if (tick_i) begin
      if (idx_q == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end
  end

  clksyn_line_decode #(.UNLOCK_PAIRS(UNLOCK_PAIRS), .IDX_W(IDX_W)) dec_i (
    .idx_i(idx_n), .word_i(word_n), .line_o(dec_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      line_q <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      err_q  <= err_n;
      idx_q  <= idx_n;
      word_q <= word_n;
      line_q <= busy_n ? dec_line : '0;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign sclk_o  = line_q.ck;
  assign sdata_o = line_q.dt;

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick_i) |=> ($stable(idx_q) && $stable({sclk_o, sdata_o}) && busy_q));
  assert_idle_lines_low_R9: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!sclk_o && !sdata_o));
  assert_word_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(word_q));
  assert_refusal_no_tx_R3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!busy_o && !done_o));
  assert_gap_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (!word_q[0] && !word_q[GAP_BIT]));
endmodule

// File: tb/clksyn_prog_seq_tb.sv
module clksyn_prog_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, start_i = 1'b0;
  logic [7:0] n_i = '0, m_i = '0;
  logic [1:0] div_i = '0, reg_i = '0;
  logic [3:0] sel_i = '0;
  logic busy_o, done_o, err_o, sclk_o, sdata_o;

  int vectors = 0, fails = 0;
  int tick_mode = 0;

  always #4 clk = ~clk;

  clksyn_prog_seq dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_i),
    .n_i(n_i), .m_i(m_i), .div_i(div_i), .sel_i(sel_i), .reg_i(reg_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o)
  );

  // Behavioural reference model
  bit [1:0] exp_q[$];
  bit m_busy = 0, m_done = 0, m_err = 0;
  int m_pos = 0;

  task automatic build_stream(input int n, input int m, input int d, input int s, input int r);
    bit [23:0] w;
    w = '0;
    w[7:1]   = 7'(m - 2);
    w[9:8]   = 2'(d);
    w[17:11] = 7'(n - 3);
    w[21:18] = 4'(s);
    w[23:22] = 2'(r);
    exp_q.delete();
    exp_q.push_back(2'b00);
    exp_q.push_back(2'b01);
    for (int i = 0; i < 6; i++) begin
      exp_q.push_back(2'b11);
      exp_q.push_back(2'b01);
    end
    exp_q.push_back(2'b00); exp_q.push_back(2'b10);
    exp_q.push_back(2'b00); exp_q.push_back(2'b10);
    for (int b = 0; b < 24; b++) begin
      exp_q.push_back({1'b1, ~w[b]});
      exp_q.push_back({1'b0, ~w[b]});
      exp_q.push_back({1'b0, w[b]});
      exp_q.push_back({1'b1, w[b]});
    end
    exp_q.push_back(2'b11); exp_q.push_back(2'b01); exp_q.push_back(2'b11);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_err = 0; m_pos = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (!m_busy) begin
        if (start_i) begin
          if (n_i >= 3 && n_i <= 130 && m_i >= 2 && m_i <= 129) begin
            build_stream(int'(n_i), int'(m_i), int'(div_i), int'(sel_i), int'(reg_i));
            m_busy = 1; m_pos = 0;
          end else m_err = 1;
        end
      end else if (tick_i) begin
        if (m_pos == exp_q.size() - 1) begin m_busy = 0; m_done = 1; end
        else m_pos++;
      end
    end
  end

  function automatic string line_tag(input int p);
    int b;
    if (p < 14) return "R4";
    if (p < 18) return "R5";
    if (p < 114) begin
      b = (p - 18) / 4;
      if (b == 0 || b == 10) return "R2";
      return "R1/R6";
    end
    return "R7";
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, expv);
    end
  endtask

  // Compare every cycle on the falling edge
  initial begin
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (rst) begin
        check("R10 busy", busy_o, 0);
        check("R10 lines", {sclk_o, sdata_o}, 0);
        check("R10 done/err", {done_o, err_o}, 0);
      end else begin
        check("R8 busy", busy_o, m_busy);
        check("R8 done", done_o, m_done);
        check("R3 err", err_o, m_err);
        if (m_busy) check(line_tag(m_pos), {sclk_o, sdata_o}, exp_q[m_pos]);
        else check("R9 idle lines", {sclk_o, sdata_o}, 0);
      end
    end
  end

  // Tick generator
  initial begin
    forever begin
      @(negedge clk);
      case (tick_mode)
        1: tick_i = ($urandom_range(0, 2) == 0);
        2: tick_i = 1'b1;
        default: tick_i = 1'b0;
      endcase
    end
  end

  task automatic req(input int n, input int m, input int d, input int s, input int r);
    @(negedge clk);
    n_i = 8'(n); m_i = 8'(m); div_i = 2'(d); sel_i = 4'(s); reg_i = 2'(r);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 R6: mixed fields, sparse ticks
    tick_mode = 1;
    req(100, 50, 1, 5, 2); wait_idle();
    // R2 boundary minima, every-cycle ticks
    tick_mode = 2;
    req(3, 2, 0, 0, 0); wait_idle();
    // R1 boundary maxima
    req(130, 129, 3, 15, 3); wait_idle();
    // R3 out-of-range refusals
    tick_mode = 1;
    req(2, 50, 0, 1, 1); repeat (3) @(negedge clk);
    req(131, 50, 0, 1, 1); repeat (3) @(negedge clk);
    req(60, 1, 0, 1, 1); repeat (3) @(negedge clk);
    req(60, 130, 0, 1, 1); repeat (3) @(negedge clk);
    // R8 hold with ticks off, then R9 ignored start while busy
    tick_mode = 0;
    req(77, 33, 2, 9, 1);
    repeat (10) @(negedge clk);
    tick_mode = 1;
    repeat (30) @(negedge clk);
    req(5, 5, 0, 0, 0);
    req(200, 1, 3, 3, 3);
    wait_idle();
    // R8 back-to-back: new start in the done cycle
    tick_mode = 2;
    req(90, 20, 1, 12, 0);
    do @(negedge clk); while (!m_done);
    n_i = 8'd45; m_i = 8'd7; div_i = 2'd3; sel_i = 4'd6; reg_i = 2'd2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule